// File: doc/BRIEF.md
# Two-Level Address Translation Buffer with Access Rights

This block turns 32-bit virtual addresses into 30-bit physical addresses for a core that has a separate instruction fetch path and a data load/store path. Instruction fetches are looked up in a small 4-entry fetch buffer. When that misses, the 64-entry shared buffer is searched. A hit there is copied into the fetch buffer and the fetch completes one cycle later than a direct hit. Only a miss in both raises a fetch miss. Data accesses look up the shared buffer only, and their result is checked against the privilege level and the access direction.

Pages are 4 KB. The 12 offset bits pass straight through, and the upper 20 bits form the virtual page number. Software fills the shared buffer one slot at a time through a write port that carries the page numbers, an address-space tag and the attribute bits. A one-cycle invalidate input empties both buffers, for example after the current address-space tag changes.

Each entry carries a 2-bit rights code. Bit 1 set means user mode may access the page, and bit 0 set means writes are allowed. So code 0 is kernel read-only, code 1 is kernel read/write, code 2 is read-only for everyone and code 3 is read/write for everyone.

Top module: `two_level_tlb`

## Requirements
- R1: A fetch that hits the fetch buffer produces `if_rsp_valid` on the cycle after the request, with `if_paddr` = {entry page number, `if_vaddr[11:0]`}.
- R2: A fetch that misses the fetch buffer but hits the shared buffer drops `if_ready` for one cycle, installs the entry and responds two cycles after the request. A later fetch to the same page then responds after one cycle.
- R3: A fetch that misses both buffers responds one cycle after the request with `if_miss` set and `if_paddr` zero.
- R4: Refills of the fetch buffer replace its slots in round-robin order, starting at slot 0 after reset. The fifth distinct page refilled therefore evicts the first one.
- R5: A data access responds one cycle after `d_req` and uses only the shared buffer. A page still present in the fetch buffer but no longer valid in the shared buffer gives a data miss.
- R6: A data access that misses the shared buffer sets `d_miss`, with `d_paddr`, `d_cacheable` and `d_wthru` all zero.
- R7: An entry with the shared bit clear matches only when its tag equals `asid_cur`. An entry with the shared bit set matches under any tag.
- R8: A data access is a rights violation (`d_prot_err`, no translation) when it is made in user mode to code 0 or 1, or when it is a write to code 0 or 2. A miss takes precedence over a violation.
- R9: A permitted write to a page whose dirty bit is clear raises `d_initwr` instead of completing. A permitted access otherwise returns the address with the page's cacheable and write-through bits.
- R10: One cycle of `inval_all` clears every valid bit in both buffers. Afterwards, fetches and data accesses to previously mapped pages miss until the shared buffer is written again.
- R11: A user-mode fetch from a code 0 or code 1 page sets `if_prot_err`. A kernel fetch from the same page translates normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| asid_cur | input | 8 | Current address-space tag |
| inval_all | input | 1 | Clear all valid bits in both buffers |
| wr_en | input | 1 | Write one shared-buffer slot |
| wr_idx | input | 6 | Slot to write |
| wr_vpn | input | 20 | Virtual page number |
| wr_asid | input | 8 | Address-space tag of the entry |
| wr_ppn | input | 18 | Physical page number |
| wr_prot | input | 2 | Rights code |
| wr_valid | input | 1 | Entry valid |
| wr_shared | input | 1 | Entry matches under any tag |
| wr_cache | input | 1 | Page is cacheable |
| wr_dirty | input | 1 | Page already written |
| wr_wthru | input | 1 | Write-through page |
| if_req | input | 1 | Fetch translation request |
| if_vaddr | input | 32 | Fetch virtual address |
| if_user | input | 1 | Fetch made in user mode |
| if_ready | output | 1 | Fetch request accepted this cycle |
| if_rsp_valid | output | 1 | Fetch response pulse |
| if_paddr | output | 30 | Fetch physical address |
| if_miss | output | 1 | Fetch miss in both buffers |
| if_prot_err | output | 1 | Fetch rights violation |
| d_req | input | 1 | Data translation request |
| d_vaddr | input | 32 | Data virtual address |
| d_write | input | 1 | Access is a write |
| d_user | input | 1 | Access made in user mode |
| d_rsp_valid | output | 1 | Data response pulse |
| d_paddr | output | 30 | Data physical address |
| d_cacheable | output | 1 | Translated page is cacheable |
| d_wthru | output | 1 | Translated page is write-through |
| d_miss | output | 1 | Data miss |
| d_prot_err | output | 1 | Data rights violation |
| d_initwr | output | 1 | First write to a clean page |

## Verification
The hardest state to reach is a fetch-buffer entry that has no valid counterpart in the shared buffer. Only then can a test show that data accesses ignore the fetch buffer and that round-robin eviction removes the right slot. The stimulus first refills the fetch buffer through a series of fetch misses to distinct pages, with every step's latency measured. It then overwrites a shared slot with an invalid entry and compares a fetch against a data access to the same page. Latency counting also checks eviction order: a refetch of a page that should have been evicted must take two cycles.

// File: rtl/tlb_pkg.sv
// Shared widths and the entry record for the two-level translation buffer.
// Assumes 32-bit virtual addresses and 4 KB pages.
package tlb_pkg;
    localparam int VA_W    = 32;
    localparam int PG_BITS = 12;
    localparam int VPN_W   = VA_W - PG_BITS;
    localparam int PPN_W   = 18;
    localparam int PA_W    = PPN_W + PG_BITS;
    localparam int ASID_W  = 8;

    // One translation entry; rights code bit1 = user allowed, bit0 = write allowed.
    typedef struct packed {
        logic              valid;
        logic              shared;
        logic              cache;
        logic              dirty;
        logic              wthru;
        logic [1:0]        prot;
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  vpn;
        logic [PPN_W-1:0]  ppn;
    } tlb_entry_t;
endpackage

// File: rtl/tlb_cam.sv
// Fully associative match over N entries.
// Assumes software keeps at most one matching entry; on duplicates the lowest index wins.
module tlb_cam
    import tlb_pkg::*;
#(
    parameter int N = 4,
    localparam int IDXW = (N > 1) ? $clog2(N) : 1
) (
    input  tlb_entry_t [N-1:0] ents,
    input  logic [VPN_W-1:0]   vpn,
    input  logic [ASID_W-1:0]  asid,
    output logic               hit,
    output logic [IDXW-1:0]    idx
);
    logic [N-1:0] match;

    // Per-entry compare: valid, page equal, and tag equal unless shared.
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = ents[g].valid && (ents[g].vpn == vpn) &&
                          (ents[g].shared || (ents[g].asid == asid));
    end

    // Priority encode the match vector.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) idx = IDXW'(i);
        end
    end

    assign hit = |match;
endmodule

// File: rtl/tlb_perm.sv
// Rights check for one access against a 2-bit rights code.
// Assumes bit1 of the code grants user access and bit0 grants writes.
module tlb_perm (
    input  logic [1:0] prot,
    input  logic       user,
    input  logic       write,
    output logic       viol
);
    // A violation is user access without the user bit, or a write without the write bit.
    assign viol = (user && !prot[1]) || (write && !prot[0]);
endmodule

// File: rtl/two_level_tlb.sv
// Two-level translation: a small fetch buffer refilled from a larger shared buffer.
// The data path searches the shared buffer only and checks rights and the dirty bit.
// Assumes requesters hold no state: each request gets exactly one response pulse.
module two_level_tlb
    import tlb_pkg::*;
#(
    parameter int ITLB_N = 4,
    parameter int UTLB_N = 64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ASID_W-1:0]         asid_cur,
    input  logic                      inval_all,
    input  logic                      wr_en,
    input  logic [$clog2(UTLB_N)-1:0] wr_idx,
    input  logic [VPN_W-1:0]          wr_vpn,
    input  logic [ASID_W-1:0]         wr_asid,
    input  logic [PPN_W-1:0]          wr_ppn,
    input  logic [1:0]                wr_prot,
    input  logic                      wr_valid,
    input  logic                      wr_shared,
    input  logic                      wr_cache,
    input  logic                      wr_dirty,
    input  logic                      wr_wthru,
    input  logic                      if_req,
    input  logic [VA_W-1:0]           if_vaddr,
    input  logic                      if_user,
    output logic                      if_ready,
    output logic                      if_rsp_valid,
    output logic [PA_W-1:0]           if_paddr,
    output logic                      if_miss,
    output logic                      if_prot_err,
    input  logic                      d_req,
    input  logic [VA_W-1:0]           d_vaddr,
    input  logic                      d_write,
    input  logic                      d_user,
    output logic                      d_rsp_valid,
    output logic [PA_W-1:0]           d_paddr,
    output logic                      d_cacheable,
    output logic                      d_wthru,
    output logic                      d_miss,
    output logic                      d_prot_err,
    output logic                      d_initwr
);
    localparam int IW = (ITLB_N > 1) ? $clog2(ITLB_N) : 1;
    localparam int UW = (UTLB_N > 1) ? $clog2(UTLB_N) : 1;

    tlb_entry_t [UTLB_N-1:0] utlb_q;
    tlb_entry_t [ITLB_N-1:0] itlb_q;
    logic [IW-1:0]           rr_q;
    logic                    if_pend;
    logic [PPN_W-1:0]        pend_ppn;
    logic [1:0]              pend_prot;
    logic                    pend_user;
    logic [PG_BITS-1:0]      pend_off;

    logic          i_hit, ui_hit, d_hit;
    logic [IW-1:0] i_idx;
    logic [UW-1:0] ui_idx, d_idx;
    logic [1:0]    i_prot;
    logic          i_user, i_viol, d_viol, d_clean_wr;

    tlb_cam #(.N(ITLB_N)) u_icam (
        .ents(itlb_q), .vpn(if_vaddr[VA_W-1:PG_BITS]), .asid(asid_cur),
        .hit(i_hit), .idx(i_idx));
    tlb_cam #(.N(UTLB_N)) u_uicam (
        .ents(utlb_q), .vpn(if_vaddr[VA_W-1:PG_BITS]), .asid(asid_cur),
        .hit(ui_hit), .idx(ui_idx));
    tlb_cam #(.N(UTLB_N)) u_dcam (
        .ents(utlb_q), .vpn(d_vaddr[VA_W-1:PG_BITS]), .asid(asid_cur),
        .hit(d_hit), .idx(d_idx));

    // Fetch rights source: the held refill entry, or the current fetch-buffer hit.
    assign i_prot = if_pend ? pend_prot : itlb_q[i_idx].prot;
    assign i_user = if_pend ? pend_user : if_user;

    tlb_perm u_iperm (.prot(i_prot), .user(i_user), .write(1'b0), .viol(i_viol));
    tlb_perm u_dperm (.prot(utlb_q[d_idx].prot), .user(d_user), .write(d_write),
                      .viol(d_viol));

    assign d_clean_wr = d_write && !utlb_q[d_idx].dirty && !d_viol;
    assign if_ready   = !if_pend;

    // Shared buffer: software slot writes; invalidate-all overrides them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            utlb_q <= '0;
        end else if (inval_all) begin
            for (int k = 0; k < UTLB_N; k++) utlb_q[k].valid <= 1'b0;
        end else if (wr_en) begin
            utlb_q[wr_idx] <= '{valid: wr_valid, shared: wr_shared, cache: wr_cache,
                                dirty: wr_dirty, wthru: wr_wthru, prot: wr_prot,
                                asid: wr_asid, vpn: wr_vpn, ppn: wr_ppn};
        end
    end

    // Fetch path: direct hit, refill-then-respond, or miss; round-robin refill slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            itlb_q       <= '0;
            rr_q         <= '0;
            if_pend      <= 1'b0;
            pend_ppn     <= '0;
            pend_prot    <= '0;
            pend_user    <= 1'b0;
            pend_off     <= '0;
            if_rsp_valid <= 1'b0;
            if_paddr     <= '0;
            if_miss      <= 1'b0;
            if_prot_err  <= 1'b0;
        end else begin
            if_rsp_valid <= 1'b0;
            if_paddr     <= '0;
            if_miss      <= 1'b0;
            if_prot_err  <= 1'b0;
            if (if_pend) begin
                if_pend      <= 1'b0;
                if_rsp_valid <= 1'b1;
                if_prot_err  <= i_viol;
                if_paddr     <= i_viol ? '0 : {pend_ppn, pend_off};
            end else if (if_req) begin
                if (i_hit) begin
                    if_rsp_valid <= 1'b1;
                    if_prot_err  <= i_viol;
                    if_paddr     <= i_viol ? '0 :
                                    {itlb_q[i_idx].ppn, if_vaddr[PG_BITS-1:0]};
                end else if (ui_hit) begin
                    if_pend      <= 1'b1;
                    pend_ppn     <= utlb_q[ui_idx].ppn;
                    pend_prot    <= utlb_q[ui_idx].prot;
                    pend_user    <= if_user;
                    pend_off     <= if_vaddr[PG_BITS-1:0];
                    itlb_q[rr_q] <= utlb_q[ui_idx];
                    rr_q         <= (rr_q == IW'(ITLB_N - 1)) ? '0 : rr_q + 1'b1;
                end else begin
                    if_rsp_valid <= 1'b1;
                    if_miss      <= 1'b1;
                end
            end
            if (inval_all) begin
                for (int k = 0; k < ITLB_N; k++) itlb_q[k].valid <= 1'b0;
            end
        end
    end

    // Data path: one-cycle response; miss beats violation beats first-write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_rsp_valid <= 1'b0;
            d_paddr     <= '0;
            d_cacheable <= 1'b0;
            d_wthru     <= 1'b0;
            d_miss      <= 1'b0;
            d_prot_err  <= 1'b0;
            d_initwr    <= 1'b0;
        end else begin
            d_rsp_valid <= d_req;
            d_miss      <= d_req && !d_hit;
            d_prot_err  <= d_req && d_hit && d_viol;
            d_initwr    <= d_req && d_hit && d_clean_wr;
            if (d_req && d_hit && !d_viol && !d_clean_wr) begin
                d_paddr     <= {utlb_q[d_idx].ppn, d_vaddr[PG_BITS-1:0]};
                d_cacheable <= utlb_q[d_idx].cache;
                d_wthru     <= utlb_q[d_idx].wthru;
            end else begin
                d_paddr     <= '0;
                d_cacheable <= 1'b0;
                d_wthru     <= 1'b0;
            end
        end
    end

    // Valid-bit views used by the checks below.
    logic [UTLB_N-1:0] u_valids;
    logic [ITLB_N-1:0] i_valids;
    for (genvar g = 0; g < UTLB_N; g++) begin : g_uv
        assign u_valids[g] = utlb_q[g].valid;
    end
    for (genvar g = 0; g < ITLB_N; g++) begin : g_iv
        assign i_valids[g] = itlb_q[g].valid;
    end

    assert_ifrsp_origin_R1: assert property (@(posedge clk) disable iff (!rst_n)
        if_rsp_valid |-> ($past(if_pend) || $past(if_req)));

    assert_refill_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        if_pend |=> (if_rsp_valid && !if_miss));

    assert_drsp_origin_R5: assert property (@(posedge clk) disable iff (!rst_n)
        d_rsp_valid |-> $past(d_req));

    assert_exc_no_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (d_miss || d_prot_err || d_initwr) |-> (d_paddr == '0 && !d_cacheable && !d_wthru));

    assert_one_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({d_miss, d_prot_err, d_initwr}) <= 1);

    assert_inval_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        inval_all |=> (u_valids == '0 && i_valids == '0));
endmodule

// File: tb/two_level_tlb_tb.sv
module two_level_tlb_tb;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n, inval_all, wr_en;
    logic [7:0]  asid_cur, wr_asid;
    logic [5:0]  wr_idx;
    logic [19:0] wr_vpn;
    logic [17:0] wr_ppn;
    logic [1:0]  wr_prot;
    logic        wr_valid, wr_shared, wr_cache, wr_dirty, wr_wthru;
    logic        if_req, if_user, if_ready, if_rsp_valid, if_miss, if_prot_err;
    logic [31:0] if_vaddr, d_vaddr;
    logic [29:0] if_paddr, d_paddr;
    logic        d_req, d_write, d_user, d_rsp_valid, d_cacheable, d_wthru;
    logic        d_miss, d_prot_err, d_initwr;

    two_level_tlb u_dut (
        .clk(clk), .rst_n(rst_n), .asid_cur(asid_cur), .inval_all(inval_all),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn), .wr_asid(wr_asid),
        .wr_ppn(wr_ppn), .wr_prot(wr_prot), .wr_valid(wr_valid),
        .wr_shared(wr_shared), .wr_cache(wr_cache), .wr_dirty(wr_dirty),
        .wr_wthru(wr_wthru), .if_req(if_req), .if_vaddr(if_vaddr),
        .if_user(if_user), .if_ready(if_ready), .if_rsp_valid(if_rsp_valid),
        .if_paddr(if_paddr), .if_miss(if_miss), .if_prot_err(if_prot_err),
        .d_req(d_req), .d_vaddr(d_vaddr), .d_write(d_write), .d_user(d_user),
        .d_rsp_valid(d_rsp_valid), .d_paddr(d_paddr), .d_cacheable(d_cacheable),
        .d_wthru(d_wthru), .d_miss(d_miss), .d_prot_err(d_prot_err),
        .d_initwr(d_initwr));

    int n_chk = 0;
    int n_err = 0;

    typedef struct packed {
        logic [31:0] va;
        logic        wr;
        logic        usr;
        logic        miss;
        logic        perr;
        logic        iw;
        logic        cache;
        logic        wt;
        logic [29:0] pa;
    } dvec_t;

    // Data-path vectors: slots 0..6 loaded below with tag 5 current.
    localparam dvec_t VEC [0:14] = '{
        '{32'h00010123, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 30'h00A00123},
        '{32'h00010FFF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 30'h00A00FFF},
        '{32'h00011004, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 30'h00A01004},
        '{32'h00011004, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 30'h0},
        '{32'h00011004, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 30'h0},
        '{32'h00012010, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 30'h00A02010},
        '{32'h00012010, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 30'h0},
        '{32'h00013020, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 30'h00A03020},
        '{32'h00013020, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 30'h0},
        '{32'h00014000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 30'h00A04000},
        '{32'h00014000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 30'h0},
        '{32'h00015000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 30'h0},
        '{32'h00016ABC, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 30'h00A06ABC},
        '{32'h00020000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 30'h0},
        '{32'h00014000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 30'h0}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr_entry(input int idx, input logic [19:0] vpn, input logic [7:0] asid,
                            input logic [1:0] prot, input logic v, input logic sh,
                            input logic ca, input logic dy, input logic wt);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 6'(idx); wr_vpn = vpn; wr_asid = asid;
        wr_ppn = 18'h00A00 + 18'(idx); wr_prot = prot; wr_valid = v;
        wr_shared = sh; wr_cache = ca; wr_dirty = dy; wr_wthru = wt;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Issue one fetch; returns cycles to response (99 if none) and if_ready seen one cycle later.
    task automatic fetch(input logic [31:0] va, input logic usr, output int lat,
                         output logic rdy1);
        @(negedge clk);
        if_req = 1'b1; if_vaddr = va; if_user = usr;
        @(negedge clk);
        if_req = 1'b0;
        lat = 1;
        rdy1 = if_ready;
        while (!if_rsp_valid && lat < 4) begin
            @(negedge clk);
            lat++;
        end
        if (!if_rsp_valid) lat = 99;
    endtask

    task automatic dacc(input logic [31:0] va, input logic wr, input logic usr);
        @(negedge clk);
        d_req = 1'b1; d_vaddr = va; d_write = wr; d_user = usr;
        @(negedge clk);
        d_req = 1'b0;
    endtask

    task automatic chk_fetch(input string req, input logic [31:0] va, input logic usr,
                             input int exp_lat, input logic emiss, input logic eperr,
                             input logic [29:0] epa);
        int lat;
        logic rdy1;
        fetch(va, usr, lat, rdy1);
        chk(lat == exp_lat, req, "fetch latency", 64'(lat), 64'(exp_lat));
        chk({if_miss, if_prot_err, if_paddr} == {emiss, eperr, epa}, req,
            "fetch {miss,prot,paddr}", {if_miss, if_prot_err, if_paddr},
            {emiss, eperr, epa});
        if (exp_lat == 2)
            chk(rdy1 == 1'b0, req, "if_ready during refill", 64'(rdy1), 64'd0);
    endtask

    task automatic chk_data(input string req, input logic [31:0] va, input logic wr,
                            input logic usr, input logic emiss, input logic eperr,
                            input logic eiw, input logic [29:0] epa);
        dacc(va, wr, usr);
        chk({d_rsp_valid, d_miss, d_prot_err, d_initwr, d_paddr} ==
            {1'b1, emiss, eperr, eiw, epa}, req, "data {rsp,miss,prot,initwr,paddr}",
            {d_rsp_valid, d_miss, d_prot_err, d_initwr, d_paddr},
            {1'b1, emiss, eperr, eiw, epa});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
        $finish;
    end

    initial begin
        rst_n = 1'b0; inval_all = 1'b0; wr_en = 1'b0; asid_cur = 8'd5;
        wr_idx = '0; wr_vpn = '0; wr_asid = '0; wr_ppn = '0; wr_prot = '0;
        wr_valid = 0; wr_shared = 0; wr_cache = 0; wr_dirty = 0; wr_wthru = 0;
        if_req = 0; if_vaddr = '0; if_user = 0;
        d_req = 0; d_vaddr = '0; d_write = 0; d_user = 0;
        repeat (3) @(negedge clk);
        chk({if_ready, if_rsp_valid, d_rsp_valid} == 3'b100, "R1", "reset state",
            {if_ready, if_rsp_valid, d_rsp_valid}, 3'b100);
        rst_n = 1'b1;

        // Slot i maps page 0x10+i to physical page 0xA00+i.
        wr_entry(0, 20'h00010, 8'd5, 2'd3, 1, 0, 1, 1, 0);
        wr_entry(1, 20'h00011, 8'd5, 2'd0, 1, 0, 1, 1, 0);
        wr_entry(2, 20'h00012, 8'd5, 2'd1, 1, 0, 1, 1, 0);
        wr_entry(3, 20'h00013, 8'd5, 2'd2, 1, 0, 1, 1, 0);
        wr_entry(4, 20'h00014, 8'd5, 2'd3, 1, 0, 1, 0, 0);
        wr_entry(5, 20'h00015, 8'd9, 2'd3, 1, 0, 1, 1, 0);
        wr_entry(6, 20'h00016, 8'd9, 2'd3, 1, 1, 0, 1, 1);

        // R5 R6 R7 R8 R9: data table walk.
        for (int i = 0; i < 15; i++) begin
            dacc(VEC[i].va, VEC[i].wr, VEC[i].usr);
            chk({d_rsp_valid, d_miss, d_prot_err, d_initwr, d_cacheable, d_wthru, d_paddr} ==
                {1'b1, VEC[i].miss, VEC[i].perr, VEC[i].iw, VEC[i].cache, VEC[i].wt, VEC[i].pa},
                "R5/R6/R7/R8/R9", $sformatf("table row %0d", i),
                {d_rsp_valid, d_miss, d_prot_err, d_initwr, d_cacheable, d_wthru, d_paddr},
                {1'b1, VEC[i].miss, VEC[i].perr, VEC[i].iw, VEC[i].cache, VEC[i].wt, VEC[i].pa});
        end

        // Fetch buffer empty after reset: refill path, then direct hit, then double miss.
        chk_fetch("R2", 32'h00010456, 0, 2, 0, 0, 30'h00A00456);
        chk_fetch("R1", 32'h00010789, 0, 1, 0, 0, 30'h00A00789);
        chk_fetch("R3", 32'h00030000, 0, 1, 1, 0, 30'h0);
        chk_fetch("R11", 32'h00011000, 1, 2, 0, 1, 30'h0);
        chk_fetch("R11", 32'h00011000, 0, 1, 0, 0, 30'h00A01000);

        // R4: slots fill 0..3, fifth refill lands in slot 0 and evicts page 0x10.
        chk_fetch("R4", 32'h00012000, 0, 2, 0, 0, 30'h00A02000);
        chk_fetch("R4", 32'h00013000, 0, 2, 0, 0, 30'h00A03000);
        chk_fetch("R4", 32'h00014000, 0, 2, 0, 0, 30'h00A04000);
        chk_fetch("R4", 32'h00011000, 0, 1, 0, 0, 30'h00A01000);
        chk_fetch("R4", 32'h00010000, 0, 2, 0, 0, 30'h00A00000);

        // R5: page 0x10 gone from shared buffer but still in fetch buffer.
        wr_entry(0, 20'h00010, 8'd5, 2'd3, 0, 0, 1, 1, 0);
        chk_fetch("R5", 32'h00010000, 0, 1, 0, 0, 30'h00A00000);
        chk_data("R5", 32'h00010000, 0, 0, 1, 0, 0, 30'h0);

        // R7: switch current tag to 9.
        asid_cur = 8'd9;
        chk_data("R7", 32'h00015000, 0, 0, 0, 0, 0, 30'h00A05000);
        chk_fetch("R7", 32'h00016000, 0, 2, 0, 0, 30'h00A06000);
        chk_data("R7", 32'h00011000, 0, 0, 1, 0, 0, 30'h0);
        asid_cur = 8'd5;

        // R10: invalidate everything, then refill one slot.
        @(negedge clk); inval_all = 1'b1;
        @(negedge clk); inval_all = 1'b0;
        chk_fetch("R10", 32'h00013000, 0, 1, 1, 0, 30'h0);
        chk_data("R10", 32'h00012000, 0, 0, 1, 0, 0, 30'h0);
        wr_entry(3, 20'h00013, 8'd5, 2'd2, 1, 0, 1, 1, 0);
        chk_fetch("R10", 32'h00013000, 0, 2, 0, 0, 30'h00A03000);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule